// File: doc/BRIEF.md
# Conversion Trigger Conditioner

This block prepares an external start pin for a converter sequencer. The raw pin is brought into the system clock domain through a synchronizer chain. A few configuration inputs then decide what the pin means. In edge mode, one selected transition of the pin produces a single-cycle request to start a conversion sequence. In level mode, the pin acts as a gate: it is active while the pin sits at the selected level. Software programs the configuration inputs, and the sequencer consumes the start pulse and the gate.

While a sequence is running, the sequencer holds a busy input high. An active transition that arrives during that time is not queued. Instead it raises a sticky overrun flag, which stays set until a clear strobe. When the enable input is low, the pin has no effect on any output.

Top module: `trig_det_top`

## Requirements
- R1: The pin passes through `SYNC_STAGES` flip-flops (default 2) before any detection, so a pin change driven before clock edge n can first affect the outputs in the cycle after edge n+1.
- R2: While `trigEn` is 0, `startPulse` and `levelGate` stay 0 and the overrun flag is never set, whatever the pin and busy inputs do.
- R3: In edge mode (`levelMode` = 0) with `polHigh` = 1, a synchronized rising transition while `seqBusy` = 0 gives `startPulse` = 1 for exactly one cycle, and a falling transition gives none.
- R4: In edge mode with `polHigh` = 0, a synchronized falling transition while not busy gives one start cycle, and a rising transition gives none.
- R5: In level mode (`levelMode` = 1), `levelGate` follows the synchronized pin when `polHigh` = 1 and its inverse when `polHigh` = 0, and `startPulse` stays 0. The gate is 0 in edge mode.
- R6: An active transition seen while `seqBusy` = 1 produces no start pulse, then or later, and sets `overrunFlag` from the next cycle on.
- R7: `overrunFlag` holds until a cycle with `flagClr` = 1 clears it for the next cycle. If a set and a clear fall in the same cycle, the flag is 1 afterwards.
- R8: After reset, all outputs are 0 and the synchronizer holds 0.
- R9: Inactive transitions, and any transition in level mode, never set the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinRaw | input | 1 | Asynchronous external trigger pin |
| trigEn | input | 1 | Enable for trigger handling |
| levelMode | input | 1 | 1 = level (gate) mode, 0 = edge mode |
| polHigh | input | 1 | 1 = high level / rising edge active, 0 = low level / falling edge active |
| seqBusy | input | 1 | Conversion sequence in progress |
| flagClr | input | 1 | Clear strobe for the overrun flag |
| startPulse | output | 1 | One-cycle sequence start request |
| levelGate | output | 1 | Gate for level-triggered operation |
| overrunFlag | output | 1 | Sticky trigger-overrun indication |

## Verification
Two functions can fall in the same cycle: the flag is set by an active transition seen while busy, and it is cleared by the clear strobe. The bench raises the pin two cycles before it asserts the clear, so that the detected transition and the clear arrive together. It then expects the flag to stay high, and to drop only after a later clear with no transition. A behavioural model that keeps a short history of the sampled pin predicts all three outputs. The outputs are compared with the model in every cycle across enable, mode, polarity and busy combinations.

// File: rtl/trig_det_pkg.sv
package trig_det_pkg;

  // Strobes from control logic to the flag-holding datapath
  typedef struct packed {
    logic ovSet;   // active transition seen while a sequence is busy
    logic ovClr;   // software clear of the overrun flag
  } trigStrobe_t;

endpackage

// File: rtl/trig_det_dp.sv
module trig_det_dp
  import trig_det_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinRaw,
  input  trigStrobe_t strb,
  output logic        pinHigh,
  output logic        pinRise,
  output logic        pinFall,
  output logic        overrunFlag
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] syncChain;
  logic         pinHist;
  logic         flagQ;

  // Synchronizer: pin enters at bit 0, the settled value leaves at MSB
  generate
    if (SYNC_STAGES < 2) begin : g_badStages
      initial $error("SYNC_STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      pinHist   <= 1'b0;
    end else begin
      syncChain <= {syncChain[MSB-1:0], pinRaw};
      pinHist   <= syncChain[MSB];
    end
  end

  assign pinHigh = syncChain[MSB];
  assign pinRise = syncChain[MSB] & ~pinHist;
  assign pinFall = ~syncChain[MSB] & pinHist;

  // Sticky overrun flag: set dominates clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            flagQ <= 1'b0;
    else if (strb.ovSet)  flagQ <= 1'b1;
    else if (strb.ovClr)  flagQ <= 1'b0;
  end

  assign overrunFlag = flagQ;

  // R7: flag persists without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !strb.ovClr) |=> flagQ);

  // R7: a set in the same cycle as a clear still leaves the flag high
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strb.ovSet |=> flagQ);

  // R7: clear without set drops the flag
  a_r7_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ovClr && !strb.ovSet) |=> !flagQ);

  // R1: the detectors never report both transitions at once
  a_r1_edge_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(pinRise && pinFall));

endmodule

// File: rtl/trig_det_ctl.sv
module trig_det_ctl
  import trig_det_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        trigEn,
  input  logic        levelMode,
  input  logic        polHigh,
  input  logic        seqBusy,
  input  logic        flagClr,
  input  logic        pinHigh,
  input  logic        pinRise,
  input  logic        pinFall,
  output logic        startPulse,
  output logic        levelGate,
  output trigStrobe_t strb
);

  logic activeEdge;
  logic activeLevel;
  logic edgeArmed;

  always_comb begin
    activeEdge  = polHigh ? pinRise : pinFall;
    activeLevel = polHigh ? pinHigh : ~pinHigh;
    edgeArmed   = trigEn & ~levelMode & activeEdge;

    startPulse  = edgeArmed & ~seqBusy;
    levelGate   = trigEn & levelMode & activeLevel;

    strb.ovSet  = edgeArmed & seqBusy;
    strb.ovClr  = flagClr;
  end

  // R2: disabled means silent
  a_r2_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !trigEn |-> (!startPulse && !levelGate && !strb.ovSet));

  // R6: no start request while busy
  a_r6_no_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    seqBusy |-> !startPulse);

  // R3: a start request lasts a single cycle
  a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);

  // R5: level mode never requests a start
  a_r5_level_no_start: assert property (@(posedge clk) disable iff (!rstN)
    levelMode |-> !startPulse);

  // R9: nothing in level mode sets the overrun flag
  a_r9_level_no_set: assert property (@(posedge clk) disable iff (!rstN)
    levelMode |-> !strb.ovSet);

endmodule

// File: rtl/trig_det_top.sv
module trig_det_top
  import trig_det_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinRaw,
  input  logic trigEn,
  input  logic levelMode,
  input  logic polHigh,
  input  logic seqBusy,
  input  logic flagClr,
  output logic startPulse,
  output logic levelGate,
  output logic overrunFlag
);

  trigStrobe_t strb;
  logic        pinHigh;
  logic        pinRise;
  logic        pinFall;

  trig_det_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .pinRaw      (pinRaw),
    .strb        (strb),
    .pinHigh     (pinHigh),
    .pinRise     (pinRise),
    .pinFall     (pinFall),
    .overrunFlag (overrunFlag)
  );

  trig_det_ctl ctl_i (
    .clk        (clk),
    .rstN       (rstN),
    .trigEn     (trigEn),
    .levelMode  (levelMode),
    .polHigh    (polHigh),
    .seqBusy    (seqBusy),
    .flagClr    (flagClr),
    .pinHigh    (pinHigh),
    .pinRise    (pinRise),
    .pinFall    (pinFall),
    .startPulse (startPulse),
    .levelGate  (levelGate),
    .strb       (strb)
  );

endmodule

// File: tb/trig_det_top_tb_top.sv
module trig_det_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinRaw = 1'b0, trigEn = 1'b0, levelMode = 1'b0, polHigh = 1'b1;
  logic seqBusy = 1'b0, flagClr = 1'b0;
  logic startPulse, levelGate, overrunFlag;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  // Model state: pin values captured at the last three clock edges (newest first)
  bit hist[$] = '{1'b0, 1'b0, 1'b0};
  bit mFlag = 1'b0;

  always #5 clk = ~clk;

  trig_det_top dut_i (
    .clk(clk), .rstN(rstN), .pinRaw(pinRaw), .trigEn(trigEn),
    .levelMode(levelMode), .polHigh(polHigh), .seqBusy(seqBusy),
    .flagClr(flagClr), .startPulse(startPulse), .levelGate(levelGate),
    .overrunFlag(overrunFlag)
  );

  task automatic check(input string req, input string what, input bit act, input bit exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare just after, advance model at posedge
  task automatic step(input bit p, input bit e, input bit m, input bit po,
                      input bit b, input bit c, input string req);
    bit hi, pv, act, lvl, expStart, expGate, setNow;
    @(negedge clk);
    pinRaw = p; trigEn = e; levelMode = m; polHigh = po; seqBusy = b; flagClr = c;
    #1;
    hi  = hist[1];
    pv  = hist[2];
    act = po ? (hi && !pv) : (!hi && pv);
    lvl = po ? hi : !hi;
    expStart = e && !m && act && !b;
    expGate  = e && m && lvl;
    setNow   = e && !m && act && b;
    check(req, "startPulse", startPulse, expStart);
    check(req, "levelGate", levelGate, expGate);
    check(req, "overrunFlag", overrunFlag, mFlag);
    @(posedge clk);
    hist.push_front(p);
    void'(hist.pop_back());
    mFlag = setNow | (mFlag & !c);
  endtask

  task automatic hold(input int n, input bit p, input bit e, input bit m,
                      input bit po, input bit b, input bit c, input string req);
    for (int i = 0; i < n; i++) step(p, e, m, po, b, c, req);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R8: reset state
    hold(3, 0, 0, 0, 1, 0, 0, "R8");
    // R2: enable low, pin and busy toggling
    for (int k = 0; k < 4; k++) hold(4, k[0], 0, k[1], 1, k[0], 0, "R2");
    hold(4, 0, 0, 0, 0, 1, 0, "R2");
    // R3/R1: rising active, falling ignored
    hold(5, 1, 1, 0, 1, 0, 0, "R3");
    hold(5, 0, 1, 0, 1, 0, 0, "R3");
    hold(2, 1, 1, 0, 1, 0, 0, "R1");
    hold(5, 0, 1, 0, 1, 0, 0, "R1");
    // R4: falling active
    hold(5, 1, 1, 0, 0, 0, 0, "R4");
    hold(5, 0, 1, 0, 0, 0, 0, "R4");
    // R9: inactive transition while busy does not set the flag
    hold(5, 1, 1, 0, 0, 1, 0, "R9");
    // R6: active transition while busy sets the flag, no start queued
    hold(5, 0, 1, 0, 0, 1, 0, "R6");
    hold(4, 0, 1, 0, 0, 0, 0, "R6");
    // R7: sticky, then clear
    hold(3, 0, 1, 0, 0, 0, 0, "R7");
    hold(1, 0, 1, 0, 0, 0, 1, "R7");
    hold(3, 0, 1, 0, 0, 0, 0, "R7");
    // R7: set and clear in the same cycle
    hold(2, 1, 1, 0, 1, 1, 0, "R7");
    hold(1, 1, 1, 0, 1, 1, 1, "R7");
    hold(3, 1, 1, 0, 1, 0, 0, "R7");
    hold(1, 1, 1, 0, 1, 0, 1, "R7");
    hold(3, 1, 1, 0, 1, 0, 0, "R7");
    // R5/R9: level mode, both polarities, busy varied
    hold(4, 0, 1, 1, 1, 0, 0, "R5");
    hold(4, 1, 1, 1, 1, 1, 0, "R5");
    hold(4, 0, 1, 1, 1, 1, 0, "R9");
    hold(4, 0, 1, 1, 0, 0, 0, "R5");
    hold(4, 1, 1, 1, 0, 1, 0, "R5");
    hold(4, 0, 1, 1, 0, 0, 0, "R5");
    // R2: disable while in level mode with active level
    hold(3, 1, 0, 1, 1, 0, 0, "R2");
    // Back to edge mode: gate must drop
    hold(4, 1, 1, 0, 1, 0, 0, "R5");
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule